// File: doc/BRIEF.md
# Oscillator Band Search Sequencer

This block chooses one of eight overlapping oscillator bands without software help. A search starts by itself when reset is released, and again every time a new feedback-divider value is loaded. The search is clocked by a slow band-step tick. That tick is made by dividing the reference-counter output pulse by 1, 2, 4 or 8.

While the search runs, the block raises a hold output. That output parks the oscillator tuning input on an internal reference instead of the loop filter. The search takes exactly five band-step ticks:

- Ticks one to three each settle one bit of a 3-bit successive-approximation code, using an external comparator flag.
- Tick four is a settling step.
- Tick five confirms the code.

On the fifth tick the code is committed and a one-cycle completion pulse is issued. The hold is then released, so normal loop action resumes. A new load during a search throws the partial result away and starts over from the first step.

All inputs are synchronous to `clk`. `ref_pulse` is a one-cycle pulse for each reference-counter output period.

Top module: `vco_band_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vtune_hold` and `band_done` are 0 and `band_code` is 000 after that edge.
- R2: At the first clock edge with `rst_n` high, a search starts by itself, so `vtune_hold` is 1 after that edge.
- R3: A clock edge that samples `n_load` high starts a search, so `vtune_hold` is 1 after that edge.
- R4: One band-step tick occurs per 1, 2, 4 or 8 `ref_pulse` cycles for `div_sel` = 00, 01, 10 or 11. The tick divider is cleared when a search starts, and `ref_pulse` on the start edge is not counted.
- R5: A search ends on the edge that samples its fifth band-step tick, which is 5 × ratio counted `ref_pulse`s after the start. `vtune_hold` falls after that edge and stays 0 until the next start.
- R6: The trial code starts at 100. On band-step ticks 1, 2 and 3, the flag `cmp_high` (1 = oscillator above target) decides bits 2, 1 and 0 in turn: the bit under test becomes the inverse of `cmp_high`, and the next lower bit is set for trial. `cmp_high` is ignored at all other times, including ticks 4 and 5.
- R7: `band_done` is a one-cycle pulse. It is high in exactly the cycle after the commit edge, together with the falling `vtune_hold`.
- R8: A start during a running search restarts it from step one with a cleared divider. `vtune_hold` stays 1 throughout.
- R9: `band_code` changes only at a commit. A partial or restarted search leaves it unchanged.
- R10: `div_sel` is captured at the start edge. Changes to it during a search have no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per reference-counter period |
| div_sel | input | 2 | Band-step divider select: 00 /1, 01 /2, 10 /4, 11 /8 |
| n_load | input | 1 | Pulse: feedback-divider value was written |
| cmp_high | input | 1 | Comparator flag, 1 = oscillator above target |
| vtune_hold | output | 1 | High while tuning is parked during a search |
| band_code | output | 3 | Last committed band |
| band_done | output | 1 | One-cycle pulse when a band is committed |

## Verification
A wrong step count or divider count shows up as `vtune_hold` falling early or late, measured in counted `ref_pulse`s, at the moment `band_done` fires. Such an error is therefore caught at the end of the very search in which it happens. A bit decided at the wrong step, or a comparator sample taken off the tick, shows up as the wrong committed `band_code` on that same completion pulse. A lost restart or a leaked divider setting shows up as an early completion relative to the latest load. A code that changes outside a commit is visible on `band_code` in the cycles between searches.

// File: rtl/vbs_pkg.sv
// Package: shared types for the oscillator band search sequencer.
// Assumes: nothing beyond the standard.
package vbs_pkg;

    // Sequencer state: idle with loop closed, or searching with tune parked.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SEARCH = 1'b1
    } seq_state_e;

endpackage

// File: rtl/vbs_step_div.sv
// Module: band-step tick divider.
// Divides the reference pulse stream by 2**sel, where sel is captured at
// search start. Emits one tick on the pulse that completes each group.
// Assumes: ref_pulse is a single-cycle pulse, and restart has priority.
module vbs_step_div #(
    parameter int DIVSEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                enable,
    input  logic                ref_pulse,
    input  logic [DIVSEL_W-1:0] div_sel,
    output logic                step_tick
);
    localparam int MAX_SH = (1 << DIVSEL_W) - 1;
    localparam int CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

    logic [DIVSEL_W-1:0] sel_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    ratio_m1;
    logic                group_end;

    // Terminal count for the captured ratio: the low sel_q bits are set.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            ratio_m1[i] = (i < int'(sel_q));
        end
    end

    assign group_end = (cnt_q == ratio_m1);
    assign step_tick = enable && ref_pulse && group_end && !restart;

    // Capture the ratio at start and count pulses within a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (restart) begin
            sel_q <= div_sel;
            cnt_q <= '0;
        end else if (enable && ref_pulse) begin
            cnt_q <= group_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_DIV_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio_m1);  // R4
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(sel_q));  // R10
endmodule

// File: rtl/vbs_sar.sv
// Module: successive-approximation register for the band code.
// Loads the mid-scale trial on restart. On step k (k < CODE_W) it sets the
// bit under test from the comparator and raises the next lower bit.
// Assumes: step_idx counts band-step ticks from zero within a search.
module vbs_sar #(
    parameter int CODE_W = 3,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step_tick,
    input  logic [STEP_W-1:0] step_idx,
    input  logic              cmp_high,
    output logic [CODE_W-1:0] trial
);
    localparam logic [CODE_W-1:0] MSB_ONE = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] trial_q;
    logic [CODE_W-1:0] trial_d;
    logic              deciding;

    // Flag the steps on which a code bit is being decided.
    assign deciding = (int'(step_idx) < CODE_W);

    // Next trial: restart value, or the decision for the current step.
    always_comb begin
        trial_d = trial_q;
        if (restart) begin
            trial_d = MSB_ONE;
        end else if (step_tick) begin
            for (int k = 0; k < CODE_W; k++) begin
                if (int'(step_idx) == k) begin
                    trial_d[CODE_W-1-k] = ~cmp_high;
                    trial_d = trial_d | (MSB_ONE >> (k + 1));
                end
            end
        end
    end

    // Hold the trial code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= MSB_ONE;
        end else begin
            trial_q <= trial_d;
        end
    end

    assign trial = trial_q;

    AST_TRIAL_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step_tick) |=> $stable(trial_q));  // R6
    AST_TRIAL_HOLD_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && step_tick && !deciding) |=> $stable(trial_q));  // R6
endmodule

// File: rtl/vbs_ctrl.sv
// Module: search sequencer.
// Starts a search on the first cycle out of reset or on a load, counts
// STEPS band-step ticks, commits the trial code on the last one and pulses
// done. The hold output is high for the whole search.
// Assumes: STEPS > CODE_W, so the trial is final before the commit tick.
module vbs_ctrl
    import vbs_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int STEPS  = 5,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              n_load,
    input  logic              step_tick,
    input  logic [CODE_W-1:0] trial,
    output logic              restart,
    output logic              searching,
    output logic [STEP_W-1:0] step_idx,
    output logic [CODE_W-1:0] band_code,
    output logic              band_done
);
    seq_state_e        state_q;
    logic              boot_q;
    logic [STEP_W-1:0] step_q;
    logic [CODE_W-1:0] code_q;
    logic              done_q;
    logic              last_step;

    assign restart   = boot_q || n_load;
    assign last_step = (step_q == STEP_W'(STEPS - 1));

    // Track the search state, step count, committed code and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q  <= 1'b1;
            state_q <= SEQ_IDLE;
            step_q  <= '0;
            code_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            boot_q <= 1'b0;
            done_q <= 1'b0;
            if (restart) begin
                state_q <= SEQ_SEARCH;
                step_q  <= '0;
            end else if (state_q == SEQ_SEARCH && step_tick) begin
                if (last_step) begin
                    state_q <= SEQ_IDLE;
                    step_q  <= '0;
                    code_q  <= trial;
                    done_q  <= 1'b1;
                end else begin
                    step_q <= step_q + STEP_W'(1);
                end
            end
        end
    end

    assign searching = (state_q == SEQ_SEARCH);
    assign step_idx  = step_q;
    assign band_code = code_q;
    assign band_done = done_q;

    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        n_load |=> searching);  // R3
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step_q) < STEPS);  // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);  // R7
    AST_HOLD_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(searching) |-> done_q);  // R7
    AST_CODE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> done_q);  // R9
endmodule

// File: rtl/vco_band_seq.sv
// Module: oscillator band search sequencer (top).
// Ties the band-step divider, the successive-approximation register and the
// sequencer together. vtune_hold is the sequencer's search state.
// Assumes: all inputs synchronous to clk, ref_pulse one cycle wide.
module vco_band_seq #(
    parameter int CODE_W   = 3,
    parameter int STEPS    = 5,
    parameter int DIVSEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_pulse,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic                n_load,
    input  logic                cmp_high,
    output logic                vtune_hold,
    output logic [CODE_W-1:0]   band_code,
    output logic                band_done
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic              restart;
    logic              searching;
    logic              step_tick;
    logic [STEP_W-1:0] step_idx;
    logic [CODE_W-1:0] trial;

    vbs_step_div #(.DIVSEL_W(DIVSEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .enable    (searching),
        .ref_pulse (ref_pulse),
        .div_sel   (div_sel),
        .step_tick (step_tick)
    );

    vbs_sar #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .step_tick (step_tick),
        .step_idx  (step_idx),
        .cmp_high  (cmp_high),
        .trial     (trial)
    );

    vbs_ctrl #(.CODE_W(CODE_W), .STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_load    (n_load),
        .step_tick (step_tick),
        .trial     (trial),
        .restart   (restart),
        .searching (searching),
        .step_idx  (step_idx),
        .band_code (band_code),
        .band_done (band_done)
    );

    assign vtune_hold = searching;
endmodule

// File: tb/tb_vco_band_seq.sv
module tb_vco_band_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       n_load = 1'b0;
    logic       cmp_high = 1'b0;
    logic       vtune_hold;
    logic [2:0] band_code;
    logic       band_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] code;
        int         pulses;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    vco_band_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .div_sel    (div_sel),
        .n_load     (n_load),
        .cmp_high   (cmp_high),
        .vtune_hold (vtune_hold),
        .band_code  (band_code),
        .band_done  (band_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: queue the expected result, then feed one full search.
    // Decisions dec[2], dec[1], dec[0] are given on ticks 1..3; the others get junk.
    task automatic run_search(input bit use_load, input logic [1:0] div,
                              input logic [2:0] dec, input int gap);
        int ratio;
        exp_t e;
        ratio = 1 << div;
        e.code = ~dec;
        e.pulses = 5 * ratio;
        exp_q.push_back(e);
        if (use_load) begin
            n_load = 1'b1;
            div_sel = div;
            @(negedge clk);
            n_load = 1'b0;
            chk(vtune_hold == 1'b1, "R3", int'(vtune_hold), 1);
        end else begin
            @(negedge clk);
            chk(vtune_hold == 1'b1, "R2", int'(vtune_hold), 1);
        end
        div_sel = ~div;  // R10: changes mid-search must be ignored
        for (int g = 0; g < 5; g++) begin
            for (int r = 0; r < ratio; r++) begin
                if (g < 3) begin
                    cmp_high = (r == ratio - 1) ? dec[2-g] : ~dec[2-g];
                end else begin
                    cmp_high = ~cmp_high;
                end
                ref_pulse = 1'b1;
                @(negedge clk);
                ref_pulse = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        chk(vtune_hold == 1'b0, "R5", int'(vtune_hold), 0);
    endtask

    // Monitor: count accepted pulses per search, and check each commit against the queue.
    initial begin
        int  cnt;
        bit  prev_hold;
        bit  prev_done;
        exp_t e;
        cnt = 0;
        prev_hold = 1'b0;
        prev_done = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                cnt = 0;
                prev_hold = 1'b0;
                prev_done = 1'b0;
            end else begin
                if (n_load) cnt = 0;
                else if (ref_pulse && prev_hold) cnt++;
                if (band_done) begin
                    chk(!prev_done, "R7", 1, 0);
                    chk(prev_hold && !vtune_hold, "R7", int'(vtune_hold), 0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(band_code == e.code, "R6", int'(band_code), int'(e.code));
                        chk(cnt == e.pulses, "R4", cnt, e.pulses);
                        chk(cnt == e.pulses, "R5", cnt, e.pulses);
                    end
                    cnt = 0;
                end
                prev_hold = vtune_hold;
                prev_done = band_done;
            end
        end
    end

    // Stimulus sequence.
    initial begin
        logic [2:0] held;
        repeat (4) @(negedge clk);
        chk(vtune_hold == 1'b0, "R1", int'(vtune_hold), 0);
        chk(band_done == 1'b0, "R1", int'(band_done), 0);
        chk(band_code == 3'b000, "R1", int'(band_code), 0);
        div_sel = 2'b00;
        rst_n = 1'b1;
        run_search(1'b0, 2'b00, 3'b101, 1);
        run_search(1'b1, 2'b01, 3'b011, 0);
        run_search(1'b1, 2'b10, 3'b110, 2);
        run_search(1'b1, 2'b11, 3'b000, 1);
        run_search(1'b1, 2'b00, 3'b111, 0);
        // R8: partial search, then restart
        held = band_code;
        n_load = 1'b1;
        div_sel = 2'b01;
        @(negedge clk);
        n_load = 1'b0;
        for (int i = 0; i < 5; i++) begin
            cmp_high = i[0];
            ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0;
        end
        chk(vtune_hold == 1'b1, "R8", int'(vtune_hold), 1);
        chk(band_code == held, "R9", int'(band_code), int'(held));
        run_search(1'b1, 2'b01, 3'b010, 1);
        held = band_code;
        repeat (6) @(negedge clk);
        chk(band_code == held, "R9", int'(band_code), int'(held));
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule